// File: doc/BRIEF.md
# Multimode 16-bit Timer with Input Capture

This block is one timer channel built around an up-counter. The counter can step on a prescaled tick from elsewhere in the chip, or on rising edges of an external pin. Two compare values are checked against the counter, which gives three uses: a periodic interval timer, an event counter, and a pulse generator whose duty and period can be programmed. A capture unit records the counter value on the rising and the falling edges of the external pin. Software uses these records to measure pulse width and repetition period. A single flip-flop drives the output pin, and an interrupt line reports compare hits.

Software reaches the block through a byte-wide register port. Every 16-bit quantity sits in two consecutive bytes, with the low byte at the even address. The period compare register is double-buffered, so a new period never cuts a pulse short.

A two-state control machine governs the counter. In `ST_IDLE` the counter is held at zero and the active period value follows its buffer. In `ST_COUNT` the counter advances on each enabled step. The transition `START` (ST_IDLE to ST_COUNT) fires when the run bit is 1. The transition `STOP` (ST_COUNT to ST_IDLE) fires when the run bit is 0. In every other case the machine stays in its current state.

Top module: `evt_timer`

## Requirements
- R1: After reset, every readable byte returns 0, and `tmr_o` and `irq_o` are low.
- R2: When the run bit (address 0x0, bit 0) is 1 and the mode bit `ext_src` (address 0x1, bit 0) is 0, the counter rises by one on each clock in which `tick_i` is high. When the run bit is 0, the counter reads 0 and ticks are ignored. Clearing the run bit returns the counter to 0.
- R3: When mode bit 1 (clear on period match) is set, a step taken while the counter equals the active period value returns the counter to 0. With a period value p, the count after n steps is therefore n mod (p+1).
- R4: Writes to the period compare bytes (0x6/0x7) land in a buffer, and reading those bytes returns the buffer. The active period value loads from the buffer only while the machine is stopped, or on a clear caused by a period match.
- R5: When `ext_src` is 1, the counter steps once per rising edge of `ext_i`, after two synchronising flops, and `tick_i` has no effect.
- R6: A step taken while the counter equals compare 0 sets status bit 0 (address 0x3). A step taken while the counter equals the active period value sets status bit 1. Writing 1 to a status bit clears it. `irq_o` is high while either status bit is set.
- R7: In the flip-flop control byte (0x2), writing bit 0 sets `tmr_o` and writing bit 1 clears it. Stored bit 2 toggles `tmr_o` on a compare-0 hit, and stored bit 3 toggles it on a period hit. Two toggles in the same step cancel. Bit 4 of this byte reads back `tmr_o`.
- R8: When mode bit 3 (pulse-generator mode) is set, both toggles and the clear on period match are forced on. With `tmr_o` starting low, the output goes high after the compare-0 hit and low after the period hit.
- R9: When mode bit 2 (capture enable) is set, a synchronised rising edge on `ext_i` copies the counter into capture A (0x8/0x9), and a falling edge copies it into capture B (0xA/0xB). Capture B minus capture A equals the high time in steps, and two successive captures into A differ by the period.
- R10: The capture bytes and the live counter bytes (0xC/0xD) are read-only, and writes to them change nothing.
- R11: Each 16-bit register places its low byte at the even address and its high byte at the next address. This holds for compare 0 (0x4/0x5), the period value (0x6/0x7), capture A, capture B and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| tick_i | input | 1 | Prescaled count enable, one clock wide per step |
| ext_i | input | 1 | External count or capture input, asynchronous |
| tmr_o | output | 1 | Timer flip-flop output |
| irq_o | output | 1 | Compare-hit interrupt, level |

## Verification
The properties assume that `tick_i` and the register port are synchronous to `clk_i`. They also assume that `ext_i` holds each level for at least one clock, so that every edge reaches the edge detector. The bench drives all inputs at the falling edge. It keeps every pin level for four clocks or more, and it reads status values only while `tick_i` is low. In every run the counter stays far below wrap-around, because the sweeps use small period values and short pulse trains.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_RUN  = 4'h0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] A_FFC  = 4'h2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h3;
    localparam logic [ADDR_W-1:0] A_CMP0 = 4'h4;
    localparam logic [ADDR_W-1:0] A_PER  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CAPA = 4'h8;
    localparam logic [ADDR_W-1:0] A_CAPB = 4'hA;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'hC;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic ppg;
        logic cap_en;
        logic clr_en;
        logic ext_src;
    } tmr_mode_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output tmr_mode_t         mode,
    output logic              tog0_en,
    output logic              tog1_en,
    output logic              ff_set,
    output logic              ff_clr,
    output logic [CNT_W-1:0]  cmp0,
    output logic [CNT_W-1:0]  per_buf,
    output logic              irq,
    input  logic              hit0,
    input  logic              hit1,
    input  logic [CNT_W-1:0]  cap_a,
    input  logic [CNT_W-1:0]  cap_b,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ff
);
    localparam int NB = CNT_W / 8;

    logic       run_q;
    tmr_mode_t  mode_q;
    logic       tog0_q, tog1_q;
    logic [1:0] flag_q;
    logic [CNT_W-1:0] cmp0_q, per_q;

    logic wr_run, wr_mode, wr_ffc, wr_stat;
    assign wr_run  = wr_en && (addr == A_RUN);
    assign wr_mode = wr_en && (addr == A_MODE);
    assign wr_ffc  = wr_en && (addr == A_FFC);
    assign wr_stat = wr_en && (addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= '0;
            tog0_q <= 1'b0;
            tog1_q <= 1'b0;
        end else begin
            if (wr_run)  run_q  <= wdata[0];
            if (wr_mode) mode_q <= tmr_mode_t'(wdata[3:0]);
            if (wr_ffc) begin
                tog0_q <= wdata[2];
                tog1_q <= wdata[3];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp0_q <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (addr == A_CMP0 + ADDR_W'(b)) cmp0_q[8*b +: 8] <= wdata;
                if (addr == A_PER + ADDR_W'(b))  per_q[8*b +: 8]  <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            if (hit0)                       flag_q[0] <= 1'b1;
            else if (wr_stat && wdata[0])   flag_q[0] <= 1'b0;
            if (hit1)                       flag_q[1] <= 1'b1;
            else if (wr_stat && wdata[1])   flag_q[1] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_RUN:   rdata = {7'b0, run_q};
            A_MODE:  rdata = {4'b0, mode_q};
            A_FFC:   rdata = {3'b0, ff, tog1_q, tog0_q, 2'b0};
            A_STAT:  rdata = {6'b0, flag_q};
            default: rdata = '0;
        endcase
        for (int b = 0; b < NB; b++) begin
            if (addr == A_CMP0 + ADDR_W'(b)) rdata = cmp0_q[8*b +: 8];
            if (addr == A_PER + ADDR_W'(b))  rdata = per_q[8*b +: 8];
            if (addr == A_CAPA + ADDR_W'(b)) rdata = cap_a[8*b +: 8];
            if (addr == A_CAPB + ADDR_W'(b)) rdata = cap_b[8*b +: 8];
            if (addr == A_CNT + ADDR_W'(b))  rdata = cnt[8*b +: 8];
        end
    end

    assign run     = run_q;
    assign mode    = mode_q;
    assign tog0_en = tog0_q;
    assign tog1_en = tog1_q;
    assign ff_set  = wr_ffc && wdata[0];
    assign ff_clr  = wr_ffc && wdata[1];
    assign cmp0    = cmp0_q;
    assign per_buf = per_q;
    assign irq     = |flag_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tmr_mode_t        mode,
    input  logic             tog0_en,
    input  logic             tog1_en,
    input  logic             ff_set,
    input  logic             ff_clr,
    input  logic             tick,
    input  logic             ext_rise,
    input  logic             ext_fall,
    input  logic [CNT_W-1:0] cmp0,
    input  logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             ff,
    output logic             hit0,
    output logic             hit1,
    output logic             step,
    output logic             wrap_clr,
    output tmr_state_e       state
);
    tmr_state_e state_q, state_d;
    logic hold_zero, count_en;
    logic [CNT_W-1:0] cnt_q, per_q, capa_q, capb_q;
    logic ff_q, flip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run)  state_d = ST_COUNT;
            ST_COUNT: if (!run) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_zero = 1'b0;
        count_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:  hold_zero = 1'b1;
            ST_COUNT: count_en  = 1'b1;
        endcase
    end

    assign step     = count_en && (mode.ext_src ? ext_rise : tick);
    assign hit0     = step && (cnt_q == cmp0);
    assign hit1     = step && (cnt_q == per_q);
    assign wrap_clr = hit1 && (mode.clr_en || mode.ppg);
    assign flip     = (hit0 && (tog0_en || mode.ppg)) ^ (hit1 && (tog1_en || mode.ppg));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else begin
            if (hold_zero)     cnt_q <= '0;
            else if (wrap_clr) cnt_q <= '0;
            else if (step)     cnt_q <= cnt_q + 1'b1;
            if (hold_zero || wrap_clr) per_q <= per_buf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capa_q <= '0;
            capb_q <= '0;
        end else if (mode.cap_en) begin
            if (ext_rise) capa_q <= cnt_q;
            if (ext_fall) capb_q <= cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ff_q <= 1'b0;
        else if (ff_set) ff_q <= 1'b1;
        else if (ff_clr) ff_q <= 1'b0;
        else if (flip)   ff_q <= ~ff_q;
    end

    assign cnt     = cnt_q;
    assign per_act = per_q;
    assign cap_a   = capa_q;
    assign cap_b   = capb_q;
    assign ff      = ff_q;
    assign state   = state_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    input  logic              ext_i,
    output logic              tmr_o,
    output logic              irq_o
);
    logic             run_w, tog0_w, tog1_w, ff_set_w, ff_clr_w;
    tmr_mode_t        mode_w;
    logic [CNT_W-1:0] cmp0_w, per_buf_w, per_act_w, cnt_w, capa_w, capb_w;
    logic             ext_rise_w, ext_fall_w, hit0_w, hit1_w, step_w, wrap_w, ff_w;
    tmr_state_e       state_w;

    tmr_edge #(.STAGES(SYNC_STGS)) u_edge (
        .clk(clk_i), .rst_n(rst_ni), .pin(ext_i),
        .rise(ext_rise_w), .fall(ext_fall_w)
    );

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .rdata(rdata_o), .run(run_w), .mode(mode_w),
        .tog0_en(tog0_w), .tog1_en(tog1_w), .ff_set(ff_set_w), .ff_clr(ff_clr_w),
        .cmp0(cmp0_w), .per_buf(per_buf_w), .irq(irq_o),
        .hit0(hit0_w), .hit1(hit1_w), .cap_a(capa_w), .cap_b(capb_w),
        .cnt(cnt_w), .ff(ff_w)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk_i), .rst_n(rst_ni), .run(run_w), .mode(mode_w),
        .tog0_en(tog0_w), .tog1_en(tog1_w), .ff_set(ff_set_w), .ff_clr(ff_clr_w),
        .tick(tick_i), .ext_rise(ext_rise_w), .ext_fall(ext_fall_w),
        .cmp0(cmp0_w), .per_buf(per_buf_w), .cnt(cnt_w), .per_act(per_act_w),
        .cap_a(capa_w), .cap_b(capb_w), .ff(ff_w), .hit0(hit0_w), .hit1(hit1_w),
        .step(step_w), .wrap_clr(wrap_w), .state(state_w)
    );

    assign tmr_o = ff_w;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       state,
    input logic             step,
    input logic             wrap_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act,
    input logic             ext_src,
    input logic             cap_en,
    input logic             ext_rise,
    input logic [CNT_W-1:0] cap_a,
    input logic             hit0,
    input logic             irq,
    input logic             ff_set,
    input logic             ff
);
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (cnt == '0));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap_clr && state == ST_COUNT) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_clr |=> (cnt == '0));

    // R4
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !wrap_clr) |=> $stable(per_act));

    // R5
    ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && ext_src && !ext_rise) |=> $stable(cnt));

    // R6
    hit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |=> irq);

    // R7
    ff_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ff_set |=> ff);

    // R9
    cap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && ext_rise) |=> (cap_a == $past(cnt)));
endmodule

bind evt_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .state(state_w), .step(step_w),
    .wrap_clr(wrap_w), .cnt(cnt_w), .per_act(per_act_w),
    .ext_src(mode_w.ext_src), .cap_en(mode_w.cap_en), .ext_rise(ext_rise_w),
    .cap_a(capa_w), .hit0(hit0_w), .irq(irq_o), .ff_set(ff_set_w), .ff(ff_w)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic       ext = 1'b0;
    logic       tmr;
    logic       irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .ext_i(ext),
        .tmr_o(tmr), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic rd16(input logic [3:0] a, output int v);
        int lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        v = lo + 256 * hi;
    endtask

    task automatic wr16(input logic [3:0] a, input int v);
        wr(a, 8'(v));
        wr(a + 4'd1, 8'(v >> 8));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic restart(input logic [7:0] md);
        wr(4'h0, 8'h00);
        wr(4'h1, md);
        wr(4'h0, 8'h01);
        cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        int v, a, b, c, k;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);

        // R1: reset state on every byte
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            chk("R1 reg byte", v, 0);
        end
        chk("R1 tmr_o", int'(tmr), 0);
        chk("R1 irq_o", int'(irq), 0);

        // R11: byte order of compare 0
        wr16(4'h4, 16'h1234);
        rd(4'h4, v); chk("R11 low byte", v, 8'h34);
        rd(4'h5, v); chk("R11 high byte", v, 8'h12);
        wr16(4'h4, 16'hFFFF);

        // R2: stopped counter ignores ticks
        ticks(5);
        rd16(4'hC, v); chk("R2 stopped", v, 0);
        restart(8'h00);
        ticks(7);
        rd16(4'hC, v); chk("R2 running count", v, 7);
        wr(4'h0, 8'h00); cyc(2);
        rd16(4'hC, v); chk("R2 stop clears", v, 0);

        // R3: period sweep, count = n mod (p+1)
        for (int pi = 0; pi < 5; pi++) begin
            int p;
            p = (pi == 4) ? 7 : pi;
            wr(4'h0, 8'h00);
            wr16(4'h6, p);
            restart(8'h02);
            for (int n = 1; n <= 12; n++) begin
                ticks(1);
                rd16(4'hC, v);
                chk("R3 wrap count", v, n % (p + 1));
            end
        end

        // R4: buffered period takes effect only at the clear
        wr(4'h0, 8'h00);
        wr16(4'h6, 5);
        restart(8'h02);
        ticks(3);
        wr16(4'h6, 2);
        rd16(4'h6, v); chk("R4 buffer readback", v, 2);
        ticks(2);
        rd16(4'hC, v); chk("R4 old period kept", v, 5);
        ticks(1);
        rd16(4'hC, v); chk("R4 clear at old period", v, 0);
        ticks(2);
        rd16(4'hC, v); chk("R4 new period reach", v, 2);
        ticks(1);
        rd16(4'hC, v); chk("R4 new period clear", v, 0);

        // R6: compare 0 flag and irq, write-one clear
        wr(4'h0, 8'h00);
        wr16(4'h4, 3);
        wr16(4'h6, 16'h0100);
        wr(4'h3, 8'h03);
        restart(8'h00);
        ticks(3);
        rd(4'h3, v); chk("R6 no flag yet", v, 0);
        chk("R6 irq low", int'(irq), 0);
        ticks(1);
        rd(4'h3, v); chk("R6 flag0 set", v, 1);
        chk("R6 irq high", int'(irq), 1);
        wr(4'h3, 8'h01);
        rd(4'h3, v); chk("R6 flag cleared", v, 0);
        chk("R6 irq dropped", int'(irq), 0);

        // R7: set, clear, readback, toggle cancel
        wr(4'h2, 8'h01);
        chk("R7 set", int'(tmr), 1);
        rd(4'h2, v); chk("R7 readback bit4", (v >> 4) & 1, 1);
        wr(4'h2, 8'h02);
        chk("R7 clear", int'(tmr), 0);
        wr(4'h0, 8'h00);
        wr16(4'h4, 2);
        wr16(4'h6, 2);
        wr(4'h2, 8'h0C);
        restart(8'h02);
        ticks(3);
        chk("R7 toggles cancel", int'(tmr), 0);
        wr(4'h2, 8'h04);
        ticks(3);
        chk("R7 single toggle", int'(tmr), 1);

        // R8: pulse generator, duty from compare 0, period from buffer
        wr(4'h0, 8'h00);
        wr(4'h2, 8'h02);
        wr16(4'h4, 2);
        wr16(4'h6, 5);
        restart(8'h08);
        c = 0; k = 0;
        for (int n = 0; n < 18; n++) begin
            bit m0, m1;
            m0 = (c == 2); m1 = (c == 5);
            if (m0 != m1) k = 1 - k;
            c = m1 ? 0 : c + 1;
            ticks(1);
            chk("R8 pulse output", int'(tmr), k);
        end

        // R9: capture, width and period
        wr(4'h0, 8'h00);
        wr(4'h2, 8'h02);
        wr16(4'h6, 16'hFFFF);
        restart(8'h04);
        @(negedge clk); tick = 1'b1;
        for (int hi = 0; hi < 4; hi++) begin
            for (int lo = 0; lo < 2; lo++) begin
                int h, l;
                h = (hi == 3) ? 12 : 6 + hi + (hi == 2 ? 1 : 0);
                l = (lo == 0) ? 6 : 9;
                @(negedge clk); ext = 1'b1;
                cyc(3);
                rd16(4'h8, a);
                cyc(h - 6);
                @(negedge clk); ext = 1'b0;
                cyc(3);
                rd16(4'hA, b);
                chk("R9 pulse width", b - a, h);
                cyc(l - 6);
                @(negedge clk); ext = 1'b1;
                cyc(3);
                rd16(4'h8, c);
                chk("R9 period", c - a, h + l);
                @(negedge clk); ext = 1'b0;
                cyc(8);
            end
        end
        @(negedge clk); tick = 1'b0;

        // R10: read-only bytes
        rd(4'h8, a);
        wr(4'h8, 8'h5A);
        rd(4'h8, v); chk("R10 capture unchanged", v, a);
        rd16(4'hC, a);
        wr(4'hC, 8'h33);
        rd16(4'hC, v); chk("R10 counter unchanged", v, a);

        // R5: external edges counted, tick ignored
        restart(8'h01);
        @(negedge clk); tick = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk); ext = 1'b1;
            cyc(4);
            @(negedge clk); ext = 1'b0;
            cyc(4);
            rd16(4'hC, v);
            chk("R5 edge count", v, n);
        end
        @(negedge clk); tick = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule